// File: doc/BRIEF.md
# Repeated Octet Tally with Coherent Byte Readout

This block keeps a 32-bit running total of the octets a network repeater has forwarded. Frame boundaries and collisions are detected outside the block, which receives them as strobes. After a valid start-of-frame strobe, the block counts repeated bits in a per-frame counter. At end of frame it adds the frame's bit count divided by eight, truncated, to the live total, unless a collision was flagged during that frame. Frames with a collision add nothing.

A host reads the total one byte at a time through a byte-wide data port. A select strobe rewinds the reader. The first read after a select takes a snapshot of the live total in a holding register and returns its least significant byte. The next reads return the higher bytes of that snapshot, whatever counting happens in between. After the fourth byte, the next read takes a fresh snapshot.

The frame tracker has three states. FRM_IDLE goes to FRM_ACTIVE on a start strobe. FRM_ACTIVE goes to FRM_IDLE on end of frame, which commits the frame's octets, and goes to FRM_SPOILED on a collision. FRM_SPOILED goes to FRM_IDLE on end of frame and commits nothing. The reader has two states. RD_FRESH goes to RD_HOLD on a read, which captures the snapshot. RD_HOLD goes back to RD_FRESH after the last byte or on a select.

Top module: `octet_tally`

## Requirements
- R1: After reset, `rd_data` is 0, the live total is 0 and the reader is in RD_FRESH, so the first four reads return 0.
- R2: A frame that ends without a collision adds floor(bits/8) to the total. A snapshot taken on any read issued after the end-of-frame cycle includes it.
- R3: Bits are counted only from the cycle after `sfd_ok` up to and including the `eof` cycle. `bit_vld` in FRM_IDLE has no effect.
- R4: A collision at any point of a frame, including the `eof` cycle itself, makes the frame add nothing.
- R5: An `eof` with no preceding `sfd_ok` adds nothing to the total.
- R6: The first `rd` in RD_FRESH copies the live total into the holding register. In the following cycle, `rd_data` holds bits 7:0 of that copy.
- R7: Each further `rd` returns the next byte of the snapshot in order: bits 15:8, then 23:16, then 31:24. Frames counted meanwhile do not change these bytes, and reading never changes the live total.
- R8: The `rd` that follows the read of bits 31:24 takes a new snapshot and returns its bits 7:0.
- R9: `sel` puts the reader in RD_FRESH at byte 0, even in the middle of a sequence. An `rd` in the same cycle as `sel` is ignored, and `rd_data` keeps its value.
- R10: `rd_data` changes only in the cycle after an accepted `rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One repeated bit in this cycle |
| sfd_ok | input | 1 | Valid start-of-frame delimiter seen (pulse) |
| coll | input | 1 | Collision flagged for the current frame |
| eof | input | 1 | End of the current frame (pulse) |
| sel | input | 1 | Host selects the counter; rewinds the reader |
| rd | input | 1 | Host data-port read strobe |
| rd_data | output | 8 | Byte returned by the last accepted read |

## Verification
The bench probes frames whose bit counts are not multiples of eight; a design that rounded up instead of truncating would report a larger total. It also probes a bit that arrives in the same cycle as `eof`, which an off-by-one tracker would drop. A collision raised in the end-of-frame cycle would slip through if the commit ignored it. A design that read bytes from the live total instead of the holding register would return torn bytes when a frame completes in the middle of a read. It also tests a select, or a select together with a read, during a read sequence. A reader that ignored that select would return the wrong byte position or change `rd_data` when it should hold.

// File: rtl/octet_tally_pkg.sv
package octet_tally_pkg;

    typedef enum logic [1:0] {
        FRM_IDLE    = 2'd0,
        FRM_ACTIVE  = 2'd1,
        FRM_SPOILED = 2'd2
    } frm_state_t;

    typedef enum logic {
        RD_FRESH = 1'b0,
        RD_HOLD  = 1'b1
    } rd_state_t;

endpackage

// File: rtl/frame_tracker.sv
module frame_tracker
    import octet_tally_pkg::*;
#(
    parameter int FBW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_vld,
    input  logic           sfd_ok,
    input  logic           coll,
    input  logic           eof,
    output frm_state_t     state_o,
    output logic           add_vld,
    output logic [FBW-4:0] add_octets
);

    frm_state_t     state_q, state_n;
    logic [FBW-1:0] bits_q;
    logic [FBW-1:0] bits_eof;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FRM_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FRM_IDLE:    if (sfd_ok) state_n = FRM_ACTIVE;
            FRM_ACTIVE: begin
                if (eof)       state_n = FRM_IDLE;
                else if (coll) state_n = FRM_SPOILED;
            end
            FRM_SPOILED: if (eof) state_n = FRM_IDLE;
            default:     state_n = FRM_IDLE;
        endcase
    end

    // per-frame bit counter, cleared when a frame opens
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (state_q == FRM_IDLE && sfd_ok) begin
            bits_q <= '0;
        end else if (state_q == FRM_ACTIVE && bit_vld) begin
            bits_q <= bits_q + FBW'(1);
        end
    end

    // outputs: the bit in the eof cycle still belongs to the frame
    always_comb begin
        bits_eof   = bits_q + FBW'(bit_vld);
        add_vld    = (state_q == FRM_ACTIVE) && eof && !coll;
        add_octets = bits_eof[FBW-1:3];
        state_o    = state_q;
    end

endmodule

// File: rtl/octet_accum.sv
module octet_accum #(
    parameter int CNT_W = 32,
    parameter int OCT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_vld,
    input  logic [OCT_W-1:0] add_octets,
    output logic [CNT_W-1:0] live_o
);

    logic [CNT_W-1:0] live_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       live_q <= '0;
        else if (add_vld) live_q <= live_q + CNT_W'(add_octets);
    end

    assign live_o = live_q;

endmodule

// File: rtl/snap_reader.sv
module snap_reader
    import octet_tally_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8,
    localparam int NB    = CNT_W / BYTE_W,
    localparam int IW    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd,
    input  logic [CNT_W-1:0]  live,
    output logic [BYTE_W-1:0] rd_data,
    output rd_state_t         state_o,
    output logic [IW-1:0]     idx_o
);

    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    rd_state_t         state_q, state_n;
    logic [IW-1:0]     idx_q, idx_n;
    logic [CNT_W-1:0]  snap_q, snap_n;
    logic [BYTE_W-1:0] data_q, data_n;
    logic [BYTE_W-1:0] snap_b [NB];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign snap_b[g] = snap_q[g*BYTE_W +: BYTE_W];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_FRESH;
            idx_q   <= '0;
            snap_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            snap_q  <= snap_n;
            data_q  <= data_n;
        end
    end

    // next state and output data
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        snap_n  = snap_q;
        data_n  = data_q;
        unique case (state_q)
            RD_FRESH: begin
                if (sel) begin
                    idx_n = '0;
                end else if (rd) begin
                    snap_n  = live;
                    data_n  = live[BYTE_W-1:0];
                    idx_n   = IW'(1);
                    state_n = RD_HOLD;
                end
            end
            RD_HOLD: begin
                if (sel) begin
                    state_n = RD_FRESH;
                    idx_n   = '0;
                end else if (rd) begin
                    data_n = snap_b[idx_q];
                    if (idx_q == LAST) begin
                        state_n = RD_FRESH;
                        idx_n   = '0;
                    end else begin
                        idx_n = idx_q + IW'(1);
                    end
                end
            end
            default: begin
                state_n = RD_FRESH;
                idx_n   = '0;
            end
        endcase
    end

    assign rd_data = data_q;
    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/octet_tally.sv
module octet_tally
    import octet_tally_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8,
    parameter int FBW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              sfd_ok,
    input  logic              coll,
    input  logic              eof,
    input  logic              sel,
    input  logic              rd,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int OCT_W = FBW - 3;
    localparam int NB    = CNT_W / BYTE_W;
    localparam int IW    = (NB > 1) ? $clog2(NB) : 1;

    frm_state_t       frm_state;
    rd_state_t        rd_state;
    logic             add_vld;
    logic [OCT_W-1:0] add_octets;
    logic [CNT_W-1:0] live_cnt;
    logic [IW-1:0]    byte_idx;

    frame_tracker #(.FBW(FBW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (bit_vld),
        .sfd_ok     (sfd_ok),
        .coll       (coll),
        .eof        (eof),
        .state_o    (frm_state),
        .add_vld    (add_vld),
        .add_octets (add_octets)
    );

    octet_accum #(.CNT_W(CNT_W), .OCT_W(OCT_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .add_vld    (add_vld),
        .add_octets (add_octets),
        .live_o     (live_cnt)
    );

    snap_reader #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_reader (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .rd      (rd),
        .live    (live_cnt),
        .rd_data (rd_data),
        .state_o (rd_state),
        .idx_o   (byte_idx)
    );

endmodule

// File: rtl/octet_tally_chk.sv
module octet_tally_chk
    import octet_tally_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8,
    parameter int IW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              rd,
    input logic [BYTE_W-1:0] rd_data,
    input logic [CNT_W-1:0]  live,
    input logic              add_vld,
    input frm_state_t        fstate,
    input rd_state_t         rstate,
    input logic [IW-1:0]     idx
);

    localparam logic [IW-1:0] LAST = IW'(CNT_W / BYTE_W - 1);

    p_live_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !add_vld |=> $stable(live));

    p_spoiled_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fstate == FRM_SPOILED) |-> !add_vld);

    p_idle_no_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fstate == FRM_IDLE) |-> !add_vld);

    p_sel_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (rstate == RD_FRESH && idx == '0));

    p_sel_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd) |=> $stable(rd_data));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rd_data));

    p_refresh_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !sel && rstate == RD_HOLD && idx == LAST) |=> (rstate == RD_FRESH));

    p_first_read_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !sel && rstate == RD_FRESH) |=> (rstate == RD_HOLD && rd_data == $past(live[BYTE_W-1:0])));

endmodule

bind octet_tally octet_tally_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .IW(IW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .rd      (rd),
    .rd_data (rd_data),
    .live    (live_cnt),
    .add_vld (add_vld),
    .fstate  (frm_state),
    .rstate  (rd_state),
    .idx     (byte_idx)
);

// File: tb/test_octet_tally.sv
module test_octet_tally;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       sfd_ok = 1'b0;
    logic       coll = 1'b0;
    logic       eof = 1'b0;
    logic       sel = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;
    logic [31:0] exp_total = '0;

    // frame bits, collision mid-frame, octets it must add (R2, R4)
    localparam int NV = 9;
    localparam int VEC_BITS [NV] = '{64, 71, 7, 1000, 12000, 8, 65535, 500, 2047};
    localparam bit VEC_COLL [NV] = '{0, 0, 0, 1, 0, 0, 0, 1, 0};
    localparam int VEC_OCT  [NV] = '{8, 8, 0, 0, 1500, 1, 8191, 0, 255};

    always #4 clk = ~clk;

    octet_tally i_octet_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .sfd_ok  (sfd_ok),
        .coll    (coll),
        .eof     (eof),
        .sel     (sel),
        .rd      (rd),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int nbits, input bit coll_mid,
                              input bit coll_eof, input bit bit_on_eof);
        @(negedge clk) sfd_ok = 1'b1;
        @(negedge clk) sfd_ok = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            bit_vld = 1'b1;
            coll = coll_mid && (i == nbits / 2);
            @(negedge clk);
        end
        bit_vld = bit_on_eof;
        coll = coll_eof;
        eof = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        coll = 1'b0;
        eof = 1'b0;
    endtask

    task automatic pulse_sel();
        @(negedge clk) sel = 1'b1;
        @(negedge clk) sel = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        b = rd_data;
    endtask

    task automatic read_all(output logic [31:0] v);
        logic [7:0] b;
        pulse_sel();
        for (int k = 0; k < 4; k++) begin
            read_byte(b);
            v[k*8 +: 8] = b;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] snap;
        logic [7:0]  b;
        logic [7:0]  held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after reset", {24'd0, rd_data}, 32'd0);
        read_byte(b);
        check("R1 first byte after reset", {24'd0, b}, 32'd0);
        read_all(v);
        check("R1 R6 total after reset", v, 32'd0);

        // table walk (R2, R4)
        for (int i = 0; i < NV; i++) begin
            send_frame(VEC_BITS[i], VEC_COLL[i], 1'b0, 1'b0);
            exp_total = exp_total + 32'(VEC_OCT[i]);
            read_all(v);
            check($sformatf("R2 R4 vector %0d", i), v, exp_total);
        end

        // R3: bits outside a frame ignored; the eof-cycle bit counts
        @(negedge clk) bit_vld = 1'b1;
        repeat (20) @(negedge clk);
        bit_vld = 1'b0;
        send_frame(7, 1'b0, 1'b0, 1'b1);
        exp_total = exp_total + 32'd1;
        read_all(v);
        check("R3 idle bits ignored, eof bit counted", v, exp_total);

        // R4: collision in the eof cycle
        send_frame(80, 1'b0, 1'b1, 1'b0);
        read_all(v);
        check("R4 collision at eof", v, exp_total);

        // R5: eof with no start of frame
        @(negedge clk) begin bit_vld = 1'b1; eof = 1'b1; end
        @(negedge clk) begin bit_vld = 1'b0; eof = 1'b0; end
        read_all(v);
        check("R5 eof without sfd", v, exp_total);

        // R7 / R8: coherence across a frame that completes mid-read
        pulse_sel();
        snap = exp_total;
        read_byte(b);
        check("R6 byte0 of snapshot", {24'd0, b}, {24'd0, snap[7:0]});
        send_frame(800, 1'b0, 1'b0, 1'b0);
        exp_total = exp_total + 32'd100;
        for (int k = 1; k < 4; k++) begin
            read_byte(b);
            check($sformatf("R7 byte%0d from snapshot", k), {24'd0, b}, {24'd0, snap[k*8 +: 8]});
        end
        read_byte(b);
        check("R8 new snapshot after last byte", {24'd0, b}, {24'd0, exp_total[7:0]});

        // R9: select in mid-sequence rewinds
        send_frame(2048, 1'b0, 1'b0, 1'b0);
        exp_total = exp_total + 32'd256;
        pulse_sel();
        read_byte(b);
        read_byte(b);
        check("R7 byte1 before rewind", {24'd0, b}, {24'd0, exp_total[15:8]});
        pulse_sel();
        read_byte(b);
        check("R9 rewind returns byte0", {24'd0, b}, {24'd0, exp_total[7:0]});

        // R9: sel and rd together, read ignored
        read_byte(b);
        held = rd_data;
        @(negedge clk) begin sel = 1'b1; rd = 1'b1; end
        @(negedge clk) begin sel = 1'b0; rd = 1'b0; end
        check("R9 sel with rd keeps rd_data", {24'd0, rd_data}, {24'd0, held});
        read_byte(b);
        check("R9 after sel with rd byte0", {24'd0, b}, {24'd0, exp_total[7:0]});

        // R10: output holds with no read, even while a frame is counted
        held = rd_data;
        send_frame(160, 1'b0, 1'b0, 1'b0);
        exp_total = exp_total + 32'd20;
        check("R10 rd_data held without rd", {24'd0, rd_data}, {24'd0, held});
        read_all(v);
        check("R2 R7 final total", v, exp_total);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule